// File: doc/BRIEF.md
# Endpoint DMA Engine with Command Decoder

This block moves bytes between an external request/acknowledge DMA port and one endpoint buffer of a USB device controller. A 32-bit down-counter holds the number of bytes still to move, and an 8-byte staging FIFO sits between the two sides. The direction is taken from `dir_in` when a transfer starts. When `dir_in` is 1 (IN), bytes go from the external port to the endpoint buffer. When it is 0 (OUT), bytes go from the endpoint buffer to the external port.

The host programs the counter through a small register port. Writing a nonzero count while the engine is idle starts a transfer. The host can also write one-byte command codes. One code pulses a clear of the endpoint's transmit buffer. One puts the engine back in its power-on state. One halts the transfer. When a halt is issued during an IN transfer, the bytes still staged are first flushed into the endpoint buffer, and the sticky interrupt is raised only after that.

The controller has three states. IDLE is the rest state. XFER means a transfer is running. DRAIN means a halted IN transfer is emptying its FIFO. The transitions are:
- *start*: IDLE to XFER.
- *finish*: XFER to IDLE when the count is exhausted.
- *halt-out*: XFER to IDLE on a halt during OUT.
- *halt-in*: XFER to DRAIN on a halt during IN.
- *drained*: DRAIN to IDLE when the FIFO is empty.
- *core-reset*: any state to IDLE.

Top module: `ep_dma_engine`

## Requirements
- R1: The count register is at address 0. It resets to 0 and reads back on `reg_rdata`. Each of the four bytes is written only where its `reg_be` bit is set. Count writes are accepted only in IDLE and are ignored in the other states.
- R2: A count write in IDLE that leaves a nonzero value starts a transfer, with the direction latched from `dir_in` (1 = IN). `ext_req` is high only in XFER with a nonzero count and with FIFO room (IN) or FIFO data (OUT).
- R3: Every cycle with `ext_req` and `ext_ack` both high lowers the count by one. A transfer ends when the count reaches 0, and for IN also only once the FIFO is empty.
- R4: The FIFO holds 8 bytes. In IN, `ext_req` drops while 8 bytes are staged. Staged bytes reach `ep_wr_data` in arrival order, one per cycle in which `ep_wr_ready` is high.
- R5: In OUT, the engine fetches from the endpoint only while fewer bytes are staged than the count. `ep_release` pulses once, after the last byte has left the external port.
- R6: Command code 0x0F (address 1, byte 0) pulses `ep_tx_clear` for one cycle per write and changes nothing else.
- R7: Command code 0x11 empties the FIFO, zeroes the count, clears the interrupt and returns the engine to IDLE.
- R8: Command code 0x13 during an IN transfer drains the FIFO one byte per clock, regardless of `ep_wr_ready`. No handshake is taken during the drain and the count is frozen. The interrupt is set one clock after the last drained byte.
- R9: Command code 0x13 during an OUT transfer discards the staged bytes without pulsing `ep_release`, returns to IDLE and sets the interrupt. In IDLE, the same code sets the interrupt on the next clock.
- R10: The interrupt appears on `irq` and on status bit 0 (address 2). It stays set until the host writes 1 to that bit. If a set and a clear fall in the same clock, the set wins.
- R11: The codes 0x10, 0x12 and 0x14 to 0xFF have no effect.
- R12: A handshake that falls in the same clock as a halt command is still accepted, counted, and included in the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 count, 1 command, 2 status |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dir_in | input | 1 | Direction for the next transfer, 1 = IN |
| ext_req | output | 1 | Request to the external DMA master |
| ext_ack | input | 1 | Acknowledge from the external master |
| ext_wdata | input | 8 | Byte from the external master (IN) |
| ext_rdata | output | 8 | Byte to the external master (OUT) |
| ep_wr_en | output | 1 | Endpoint buffer write strobe |
| ep_wr_data | output | 8 | Endpoint buffer write byte |
| ep_wr_ready | input | 1 | Endpoint buffer can take a byte |
| ep_rd_en | output | 1 | Endpoint buffer read strobe |
| ep_rd_data | input | 8 | Endpoint buffer byte, valid with `ep_rd_avail` |
| ep_rd_avail | input | 1 | Endpoint buffer has a byte |
| ep_release | output | 1 | OUT buffer may be released |
| ep_tx_clear | output | 1 | Clear one transmit buffer of the endpoint |
| irq | output | 1 | Sticky halt-complete interrupt |

## Verification
Two collisions are provoked on purpose.

The first collision puts a halt command in the same clock as an external handshake. It is provoked by writing the halt in the cycle directly after the count write. The bench then checks three things: the byte was counted, it came out of the drain, and the count equals the start value minus the handshakes the bench itself observed.

The second collision puts the drain-complete interrupt set in the same clock as a host write-1-to-clear. It is provoked by holding clear writes through the whole drain and one clock beyond. After that, `irq` must still read 1.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2
    } dma_state_t;

    localparam logic [7:0] OP_CLR_TX = 8'h0F;
    localparam logic [7:0] OP_RESET  = 8'h11;
    localparam logic [7:0] OP_STOP   = 8'h13;

    localparam logic [1:0] RA_COUNT  = 2'd0;
    localparam logic [1:0] RA_CMD    = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;
endpackage

// File: rtl/ep_dma_fifo.sv
module ep_dma_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   push,
    input  logic                   pop,
    input  logic [W-1:0]           din,
    output logic [W-1:0]           dout,
    output logic                   full,
    output logic                   empty,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            level <= level + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ep_dma_count.sv
module ep_dma_count #(
    parameter int CW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [CW/8-1:0] be,
    input  logic [CW-1:0]   wdata,
    input  logic            dec,
    output logic [CW-1:0]   cnt,
    output logic            load_nz
);
    localparam int LANES = CW / 8;

    logic [CW-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : cnt[g*8 +: 8];
    end

    assign load_nz = wr_en && (merged != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (wr_en)  cnt <= merged;
        else if (dec)    cnt <= cnt - CW'(1);
    end

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !wr_en) |=> (cnt == $past(cnt) - CW'(1)));
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));
endmodule

// File: rtl/ep_dma_engine.sv
module ep_dma_engine
    import ep_dma_pkg::*;
#(
    parameter int CW         = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [CW/8-1:0] reg_be,
    input  logic [CW-1:0]   reg_wdata,
    output logic [CW-1:0]   reg_rdata,
    input  logic            dir_in,
    output logic            ext_req,
    input  logic            ext_ack,
    input  logic [7:0]      ext_wdata,
    output logic [7:0]      ext_rdata,
    output logic            ep_wr_en,
    output logic [7:0]      ep_wr_data,
    input  logic            ep_wr_ready,
    output logic            ep_rd_en,
    input  logic [7:0]      ep_rd_data,
    input  logic            ep_rd_avail,
    output logic            ep_release,
    output logic            ep_tx_clear,
    output logic            irq
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    dma_state_t    state, state_n;
    logic          dir_q;
    logic [CW-1:0] cnt;
    logic          load_nz;
    logic          fifo_full, fifo_empty, fifo_flush, fifo_push, fifo_pop;
    logic [7:0]    fifo_dout;
    logic [LW-1:0] fifo_level;
    logic          cmd_wr, cmd_clr, cmd_rst, cmd_stop, irq_clr_wr, irq_set;
    logic          cnt_wr, fire, cnt_zero;

    // ---- register decode ----
    assign cmd_wr     = reg_wr && (reg_addr == RA_CMD) && reg_be[0];
    assign cmd_clr    = cmd_wr && (reg_wdata[7:0] == OP_CLR_TX);
    assign cmd_rst    = cmd_wr && (reg_wdata[7:0] == OP_RESET);
    assign cmd_stop   = cmd_wr && (reg_wdata[7:0] == OP_STOP);
    assign irq_clr_wr = reg_wr && (reg_addr == RA_STATUS) && reg_be[0] && reg_wdata[0];
    assign cnt_wr     = reg_wr && (reg_addr == RA_COUNT) && (state == ST_IDLE);
    assign fire       = ext_req && ext_ack;
    assign cnt_zero   = (cnt == '0);

    always_comb begin
        case (reg_addr)
            RA_COUNT:  reg_rdata = cnt;
            RA_STATUS: reg_rdata = {{(CW-1){1'b0}}, irq};
            default:   reg_rdata = '0;
        endcase
    end

    // ---- datapath ----
    ep_dma_count #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .wr_en(cnt_wr),
        .be(reg_be), .wdata(reg_wdata), .dec(fire),
        .cnt(cnt), .load_nz(load_nz)
    );

    assign fifo_flush = cmd_rst || (state == ST_XFER && !dir_q && cmd_stop);
    assign fifo_push  = dir_q ? fire : ep_rd_en;
    assign fifo_pop   = dir_q ? ep_wr_en : fire;

    ep_dma_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
        .push(fifo_push), .pop(fifo_pop),
        .din(dir_q ? ext_wdata : ep_rd_data),
        .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty),
        .level(fifo_level)
    );

    assign ep_wr_data  = fifo_dout;
    assign ext_rdata   = fifo_dout;
    assign ep_tx_clear = cmd_clr;

    // ---- next state ----
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (load_nz) state_n = ST_XFER;
            ST_XFER: begin
                if (cmd_stop)                        state_n = dir_q ? ST_DRAIN : ST_IDLE;
                else if (dir_q && cnt_zero && fifo_empty) state_n = ST_IDLE;
                else if (!dir_q && cnt_zero)         state_n = ST_IDLE;
            end
            ST_DRAIN: if (fifo_empty) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        if (cmd_rst) state_n = ST_IDLE;
    end

    assign irq_set = (cmd_stop && (state == ST_IDLE || (state == ST_XFER && !dir_q)))
                   || (state == ST_DRAIN && fifo_empty);

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dir_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && load_nz) dir_q <= dir_in;
            if (cmd_rst)         irq <= 1'b0;
            else if (irq_set)    irq <= 1'b1;
            else if (irq_clr_wr) irq <= 1'b0;
        end
    end

    // ---- outputs ----
    always_comb begin
        ext_req    = 1'b0;
        ep_wr_en   = 1'b0;
        ep_rd_en   = 1'b0;
        ep_release = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                if (dir_q) begin
                    ext_req  = !cnt_zero && !fifo_full;
                    ep_wr_en = !fifo_empty && ep_wr_ready;
                end else begin
                    ext_req    = !cnt_zero && !fifo_empty;
                    ep_rd_en   = ep_rd_avail && !fifo_full && !fifo_flush
                                 && (cnt > {{(CW-LW){1'b0}}, fifo_level});
                    ep_release = cnt_zero;
                end
            end
            ST_DRAIN: ep_wr_en = !fifo_empty;
            default: ;
        endcase
    end

    // ---- assertions ----
    a_r9_idle_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_stop) |=> irq);
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr_wr && !cmd_rst) |=> irq);
    a_r5_release_drained: assert property (@(posedge clk) disable iff (!rst_n)
        ep_release |-> fifo_empty);
    a_r8_drain_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !cmd_rst) |=> $stable(cnt));
endmodule

// File: tb/tb_ep_dma_engine.sv
module tb_ep_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dir_in = 1'b1;
    logic        ext_req, ext_ack = 1'b0;
    logic [7:0]  ext_wdata = 8'h0, ext_rdata;
    logic        ep_wr_en, ep_wr_ready = 1'b1;
    logic [7:0]  ep_wr_data;
    logic        ep_rd_en, ep_rd_avail = 1'b0;
    logic [7:0]  ep_rd_data = 8'h0;
    logic        ep_release, ep_tx_clear, irq;

    always #4 clk = ~clk;

    ep_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dir_in(dir_in), .ext_req(ext_req), .ext_ack(ext_ack),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ep_wr_en(ep_wr_en), .ep_wr_data(ep_wr_data), .ep_wr_ready(ep_wr_ready),
        .ep_rd_en(ep_rd_en), .ep_rd_data(ep_rd_data), .ep_rd_avail(ep_rd_avail),
        .ep_release(ep_release), .ep_tx_clear(ep_tx_clear), .irq(irq)
    );

    int   checks = 0, errors = 0;
    int   fires, ep_cnt, rd_cnt, rel_cnt, clr_cnt, mism;
    logic env_on = 1'b0, avail_on = 1'b0, ready_force = 1'b1, throttle = 1'b0;
    logic pend_in = 1'b0, pend_out = 1'b0;
    logic [7:0] ext_exp = 8'h0, ep_exp = 8'h0;

    // bit 32: 1 = IN, bits 31:0: byte count
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 32'd1}, {1'b1, 32'd5}, {1'b1, 32'd20},
        {1'b0, 32'd1}, {1'b0, 32'd8}, {1'b0, 32'd13}
    };

    // environment: external master and endpoint buffer models
    always @(negedge clk) begin
        if (pend_in)  ext_wdata  = ext_wdata + 8'd1;
        if (pend_out) ep_rd_data = ep_rd_data + 8'd1;
        pend_in  = 1'b0;
        pend_out = 1'b0;
        ep_wr_ready = throttle ? !ep_wr_ready : ready_force;
        ep_rd_avail = avail_on;
        ext_ack     = env_on && ext_req;
        #1;
        if (ext_req && ext_ack) begin
            fires++;
            if (dir_in) pend_in = 1'b1;
            else begin
                if (ext_rdata !== ext_exp) mism++;
                ext_exp = ext_exp + 8'd1;
            end
        end
        if (ep_wr_en) begin
            if (ep_wr_data !== ep_exp) mism++;
            ep_exp = ep_exp + 8'd1;
            ep_cnt++;
        end
        if (ep_rd_en)    begin pend_out = 1'b1; rd_cnt++; end
        if (ep_release)  rel_cnt++;
        if (ep_tx_clear) clr_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic req_now(output logic r);
        #1 r = ext_req;
        @(negedge clk);
    endtask

    task automatic prep(input logic [7:0] seed);
        env_on = 1'b0; avail_on = 1'b0; throttle = 1'b0;
        cyc(2);
        ext_wdata = seed; ep_rd_data = seed; ext_exp = seed; ep_exp = seed;
        pend_in = 1'b0; pend_out = 1'b0;
        fires = 0; ep_cnt = 0; rd_cnt = 0; rel_cnt = 0; clr_cnt = 0; mism = 0;
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        r;
        logic        isin;
        logic [31:0] n;
        cyc(3);
        rst_n = 1'b1;
        prep(8'h00);

        // reset state
        rd(2'd0, v); chk("R1 count after reset", v, 32'h0);
        rd(2'd2, v); chk("R10 irq after reset", v, 32'h0);
        req_now(r);  chk("R2 no request after reset", {31'b0, r}, 32'h1 - 32'h1);

        // byte lanes, start, locked writes, reserved codes
        dir_in = 1'b1;
        wr(2'd0, 4'b0101, 32'hAABBCCDD);
        rd(2'd0, v); chk("R1 byte lane write", v, 32'h00BB00DD);
        req_now(r);  chk("R2 request after start", {31'b0, r}, 32'h1);
        wr(2'd0, 4'hF, 32'h1);
        rd(2'd0, v); chk("R1 write ignored in XFER", v, 32'h00BB00DD);
        wr(2'd1, 4'h1, 32'h10);
        wr(2'd1, 4'h1, 32'h12);
        wr(2'd1, 4'h1, 32'h14);
        wr(2'd1, 4'h1, 32'hFF);
        rd(2'd0, v); chk("R11 reserved keep count", v, 32'h00BB00DD);
        rd(2'd2, v); chk("R11 reserved keep irq", v, 32'h0);
        req_now(r);  chk("R11 reserved keep request", {31'b0, r}, 32'h1);
        chk("R11 reserved no tx clear", 32'(clr_cnt), 32'h0);

        // FIFO capacity
        ready_force = 1'b0; env_on = 1'b1;
        cyc(12);
        chk("R4 fifo takes eight", 32'(fires), 32'd8);
        rd(2'd0, v); chk("R3 count after eight", v, 32'h00BB00DD - 32'd8);
        req_now(r);  chk("R4 request low when full", {31'b0, r}, 32'h0);
        chk("R4 nothing to endpoint when not ready", 32'(ep_cnt), 32'h0);

        // core reset
        env_on = 1'b0; cyc(1);
        wr(2'd1, 4'h1, 32'h11);
        rd(2'd0, v); chk("R7 count zeroed", v, 32'h0);
        req_now(r);  chk("R7 idle no request", {31'b0, r}, 32'h0);
        prep(8'h40);
        dir_in = 1'b1; ready_force = 1'b0; env_on = 1'b1; cyc(1);
        wr(2'd0, 4'hF, 32'd12);
        cyc(20);
        chk("R7 fifo emptied by reset", 32'(fires), 32'd8);
        rd(2'd0, v); chk("R3 count four left", v, 32'd4);

        // halt during IN: drain, and set against clear in one clock
        wr(2'd1, 4'h1, 32'h13);
        for (int k = 0; k < 9; k++) wr(2'd2, 4'h1, 32'h1);
        rd(2'd2, v); chk("R10 set wins over clear", v, 32'h1);
        chk("R8 drained all staged", 32'(ep_cnt), 32'd8);
        chk("R8 drain order", 32'(mism), 32'd0);
        chk("R8 no handshake in drain", 32'(fires), 32'd8);
        rd(2'd0, v); chk("R8 count frozen", v, 32'd4);
        cyc(3);
        rd(2'd2, v); chk("R10 irq sticky", v, 32'h1);
        wr(2'd2, 4'h1, 32'h1);
        rd(2'd2, v); chk("R10 irq cleared", v, 32'h0);

        // halt in IDLE
        env_on = 1'b0; cyc(1);
        wr(2'd1, 4'h1, 32'h13);
        rd(2'd2, v); chk("R9 idle halt irq", v, 32'h1);
        wr(2'd2, 4'h1, 32'h1);

        // halt during OUT
        prep(8'h80);
        dir_in = 1'b0; avail_on = 1'b1; cyc(1);
        wr(2'd0, 4'hF, 32'd10);
        cyc(12);
        chk("R5 fetch limited by fifo", 32'(rd_cnt), 32'd8);
        wr(2'd1, 4'h1, 32'h13);
        rd(2'd2, v); chk("R9 out halt irq", v, 32'h1);
        chk("R9 no release on halt", 32'(rel_cnt), 32'd0);
        rd(2'd0, v); chk("R9 count kept", v, 32'd10);
        req_now(r);  chk("R9 no request after halt", {31'b0, r}, 32'h0);
        wr(2'd2, 4'h1, 32'h1);

        // transmit clear
        avail_on = 1'b0; cyc(1);
        clr_cnt = 0;
        wr(2'd1, 4'h1, 32'h0F);
        chk("R6 one pulse per command", 32'(clr_cnt), 32'd1);
        wr(2'd1, 4'h1, 32'h0F);
        chk("R6 second pulse", 32'(clr_cnt), 32'd2);
        rd(2'd0, v); chk("R6 count untouched", v, 32'd10);
        rd(2'd2, v); chk("R6 irq untouched", v, 32'h0);

        // halt in the same clock as a handshake
        wr(2'd1, 4'h1, 32'h11);
        prep(8'hC0);
        dir_in = 1'b1; ready_force = 1'b0; env_on = 1'b1; cyc(1);
        wr(2'd0, 4'hF, 32'd5);
        wr(2'd1, 4'h1, 32'h13);
        cyc(15);
        chk("R12 handshake taken with halt", 32'(fires), 32'd1);
        chk("R12 byte drained", 32'(ep_cnt), 32'(fires));
        rd(2'd0, v); chk("R12 count reflects handshake", v, 32'd5 - 32'(fires));
        rd(2'd2, v); chk("R12 irq after drain", v, 32'h1);
        wr(2'd2, 4'h1, 32'h1);

        // transfer table
        for (int i = 0; i < 6; i++) begin
            isin = VEC[i][32];
            n    = VEC[i][31:0];
            prep(8'(i * 37));
            dir_in = isin; ready_force = 1'b1; cyc(1);
            throttle = 1'(i % 2); env_on = 1'b1; avail_on = 1'b1; cyc(1);
            wr(2'd0, 4'hF, n);
            cyc(4 * int'(n) + 20);
            rd(2'd0, v); chk("R3 count runs to zero", v, 32'h0);
            if (isin) begin
                chk("R4 IN bytes delivered", 32'(ep_cnt), n);
                chk("R2 IN has no release", 32'(rel_cnt), 32'd0);
            end else begin
                chk("R5 OUT bytes sent", 32'(fires), n);
                chk("R5 one release", 32'(rel_cnt), 32'd1);
            end
            chk("R4 byte order", 32'(mism), 32'd0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule